// File: doc/BRIEF.md
# Paged Ping-Pong Buffer Memory

This block is a dual-sided memory split into a fixed number of equal pages. A producer writes words into its current page and a consumer reads words from its own current page. Each side uses only a short local address that selects a word within its page. The page itself comes from a pointer that the side keeps. A one-cycle advance pulse moves that pointer to the next page in rotation. The two pointers start on different pages, so a page filled by the writer can be drained by the reader once the reader's rotation reaches it.

Each side has its own clock, synchronous active-high reset and clock enable, so the two sides may run in separate clock domains. A read returns its word one cycle after the request, together with a valid flag. The read word stays on the output until the next read.

A string parameter picks how the page becomes a physical location:
- `MUX` uses one storage bank per page, with a page select on the read side.
- `CONCAT` places the page index above the local address in one flat array. This form needs a power-of-two page size.
- `OFFSET` adds page × page size to the local address in one flat array.

All three forms must give the same outputs on every cycle.

Top module: `pingpong_page_ram`

## Requirements
- R1: The write page pointer starts at WR_START after reset. Each cycle with wr_ce and wr_page_adv high moves it one page on, and it wraps from page PAGES-1 back to page 0.
- R2: The read page pointer follows the same rules on rd_clk. It starts at RD_START and is driven by rd_page_adv, independently of the write pointer.
- R3: An advance pulse takes effect from the following cycle. A write or read in the same cycle as the pulse still uses the old page.
- R4: rd_valid is high in exactly the cycle after a cycle with rd_ce and rd_en high. rd_data then carries the word stored at the read page and rd_addr sampled with the request.
- R5: When no read is returned, rd_valid is low and rd_data keeps the last word that was read.
- R6: While a side's clock enable is low, that side is frozen. A low wr_ce means no write lands and the write pointer does not move. A low rd_ce means the read pointer, rd_valid and rd_data do not change.
- R7: The MUX, CONCAT and OFFSET forms give identical rd_data and rd_valid on every cycle for the same stimulus.
- R8: Pages can be switched back to back. The advance pulse may share the cycle of the last write to a page, and the first write to the next page may come on the following cycle, with no word lost.
- R9: During and right after reset, rd_valid and rd_data are 0. Reset does not clear stored words.
- R10: The same local address on different pages refers to separate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write side clock |
| wr_rst | input | 1 | Write side synchronous reset, active high |
| wr_ce | input | 1 | Write side clock enable |
| wr_page_adv | input | 1 | Advance the write page pointer |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word address within the write page |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read side clock |
| rd_rst | input | 1 | Read side synchronous reset, active high |
| rd_ce | input | 1 | Read side clock enable |
| rd_page_adv | input | 1 | Advance the read page pointer |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Word address within the read page |
| rd_data | output | DATA_W | Word returned one cycle after the request |
| rd_valid | output | 1 | rd_data holds a new word |

## Verification
The bench builds three copies with three pages of eight 8-bit words, write start page 0 and read start page 1, one copy per mapping form, all fed by one shared stimulus. Using three pages rather than two makes the wrap from the last page to page 0 differ from a plain toggle. It also lets one pointer run a full page ahead of the other, so reading one page while writing another can be exercised. Comparing the three copies every cycle covers the requirement that the forms agree.

// File: rtl/pingpong_page_ram.sv
module pingpong_page_ram #(
  parameter int    DATA_W     = 8,
  parameter int    PAGES      = 2,
  parameter int    PAGE_WORDS = 8,
  parameter int    WR_START   = 0,
  parameter int    RD_START   = 1,
  parameter string MAP        = "MUX",
  localparam int   AW         = $clog2(PAGE_WORDS)
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_ce,
  input  logic              wr_page_adv,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_ce,
  input  logic              rd_page_adv,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int GW = $clog2(PAGES);

  logic [GW-1:0] wr_page, rd_page;

  function automatic logic [GW-1:0] next_page(input logic [GW-1:0] p);
    return (int'(p) == PAGES - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge wr_clk)
    if (wr_rst) wr_page <= GW'(WR_START);
    else if (wr_ce && wr_page_adv) wr_page <= next_page(wr_page);

  always_ff @(posedge rd_clk)
    if (rd_rst) rd_page <= GW'(RD_START);
    else if (rd_ce && rd_page_adv) rd_page <= next_page(rd_page);

  always_ff @(posedge rd_clk)
    if (rd_rst) rd_valid <= 1'b0;
    else if (rd_ce) rd_valid <= rd_en;

  generate
    if (MAP == "MUX") begin : g_mux
      logic [DATA_W-1:0] bank_rd [PAGES];
      logic [GW-1:0]     rd_sel;

      for (genvar p = 0; p < PAGES; p++) begin : g_bank
        logic [DATA_W-1:0] bank [PAGE_WORDS];
        logic [DATA_W-1:0] q;

        always_ff @(posedge wr_clk)
          if (wr_ce && wr_en && wr_page == GW'(p)) bank[wr_addr] <= wr_data;

        always_ff @(posedge rd_clk)
          if (rd_rst) q <= '0;
          else if (rd_ce && rd_en) q <= bank[rd_addr];

        assign bank_rd[p] = q;
      end

      always_ff @(posedge rd_clk)
        if (rd_rst) rd_sel <= '0;
        else if (rd_ce && rd_en) rd_sel <= rd_page;

      assign rd_data = bank_rd[rd_sel];
    end else begin : g_flat
      localparam int DEPTH = (MAP == "CONCAT") ? (PAGES << AW) : (PAGES * PAGE_WORDS);
      localparam int PA    = $clog2(DEPTH);

      logic [DATA_W-1:0] mem [DEPTH];
      logic [PA-1:0]     wr_phys, rd_phys;
      logic [DATA_W-1:0] rd_q;

      if (MAP == "CONCAT") begin : g_cat
        assign wr_phys = PA'({wr_page, wr_addr});
        assign rd_phys = PA'({rd_page, rd_addr});
      end else begin : g_ofs
        assign wr_phys = PA'(int'(wr_page) * PAGE_WORDS + int'(wr_addr));
        assign rd_phys = PA'(int'(rd_page) * PAGE_WORDS + int'(rd_addr));
      end

      always_ff @(posedge wr_clk)
        if (wr_ce && wr_en) mem[wr_phys] <= wr_data;

      always_ff @(posedge rd_clk)
        if (rd_rst) rd_q <= '0;
        else if (rd_ce && rd_en) rd_q <= mem[rd_phys];

      assign rd_data = rd_q;
    end
  endgenerate
endmodule

module pingpong_page_ram_chk #(
  parameter int DATA_W = 8,
  parameter int PAGES  = 2
) (
  input logic                     wr_clk,
  input logic                     wr_rst,
  input logic                     wr_ce,
  input logic                     wr_page_adv,
  input logic [$clog2(PAGES)-1:0] wr_page,
  input logic                     rd_clk,
  input logic                     rd_rst,
  input logic                     rd_ce,
  input logic                     rd_page_adv,
  input logic                     rd_en,
  input logic [$clog2(PAGES)-1:0] rd_page,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     rd_valid
);
  // R1
  wr_page_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_ce && wr_page_adv |=> wr_page == ((int'($past(wr_page)) == PAGES - 1) ? '0 : $past(wr_page) + 1'b1));

  // R1
  wr_page_range_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    int'(wr_page) < PAGES);

  // R2
  rd_page_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ce && rd_page_adv |=> rd_page == ((int'($past(rd_page)) == PAGES - 1) ? '0 : $past(rd_page) + 1'b1));

  // R4
  rd_latency_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ce |=> rd_valid == $past(rd_en));

  // R5
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ce && !rd_en |=> $stable(rd_data));

  // R6
  wr_freeze_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_ce |=> $stable(wr_page));

  // R6
  rd_freeze_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_ce |=> $stable(rd_page) && $stable(rd_valid) && $stable(rd_data));
endmodule

bind pingpong_page_ram pingpong_page_ram_chk #(.DATA_W(DATA_W), .PAGES(PAGES)) chk_i (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_ce(wr_ce), .wr_page_adv(wr_page_adv), .wr_page(wr_page),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_ce(rd_ce), .rd_page_adv(rd_page_adv), .rd_en(rd_en),
  .rd_page(rd_page), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/pingpong_page_ram_test.sv
`timescale 1ns/1ps
module pingpong_page_ram_test;
  localparam int P = 3, W = 8, DW = 8, AW = 3;

  logic clk = 0, rst = 1;
  logic wce = 1, wadv = 0, wen = 0, rce = 1, radv = 0, ren = 0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] d_mux, d_cat, d_ofs;
  logic v_mux, v_cat, v_ofs;

  always #10 clk = ~clk;

  pingpong_page_ram #(.DATA_W(DW), .PAGES(P), .PAGE_WORDS(W), .WR_START(0), .RD_START(1), .MAP("MUX")) uut (
    .wr_clk(clk), .wr_rst(rst), .wr_ce(wce), .wr_page_adv(wadv), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
    .rd_clk(clk), .rd_rst(rst), .rd_ce(rce), .rd_page_adv(radv), .rd_en(ren), .rd_addr(raddr),
    .rd_data(d_mux), .rd_valid(v_mux));
  pingpong_page_ram #(.DATA_W(DW), .PAGES(P), .PAGE_WORDS(W), .WR_START(0), .RD_START(1), .MAP("CONCAT")) uut_cat (
    .wr_clk(clk), .wr_rst(rst), .wr_ce(wce), .wr_page_adv(wadv), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
    .rd_clk(clk), .rd_rst(rst), .rd_ce(rce), .rd_page_adv(radv), .rd_en(ren), .rd_addr(raddr),
    .rd_data(d_cat), .rd_valid(v_cat));
  pingpong_page_ram #(.DATA_W(DW), .PAGES(P), .PAGE_WORDS(W), .WR_START(0), .RD_START(1), .MAP("OFFSET")) uut_ofs (
    .wr_clk(clk), .wr_rst(rst), .wr_ce(wce), .wr_page_adv(wadv), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
    .rd_clk(clk), .rd_rst(rst), .rd_ce(rce), .rd_page_adv(radv), .rd_en(ren), .rd_addr(raddr),
    .rd_data(d_ofs), .rd_valid(v_ofs));

  typedef struct { int data; int due; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  int wp = 0, rp = 1, last = 0;
  int mdl [P*W];
  bit mon_on = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit we, input int wa, input int wd, input bit wa_adv, input bit w_ce,
                      input bit re, input int ra, input bit ra_adv, input bit r_ce, input string tag);
    exp_t e;
    @(posedge clk); #1;
    wen = we; waddr = AW'(wa); wdata = DW'(wd); wadv = wa_adv; wce = w_ce;
    ren = re; raddr = AW'(ra); radv = ra_adv; rce = r_ce;
    if (r_ce && re) begin
      e.data = mdl[rp*W + ra]; e.due = cyc + 1; e.tag = tag;
      q.push_back(e);
    end
    if (r_ce && ra_adv) rp = (rp + 1) % P;
    if (w_ce && we) mdl[wp*W + wa] = wd;
    if (w_ce && wa_adv) wp = (wp + 1) % P;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 1, "");
  endtask

  task automatic fill(input int base, input string tag);
    for (int i = 0; i < W; i++) step(1, i, base + i, i == W-1, 1, 0, 0, 0, 1, tag);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < W; i++) step(0, 0, 0, 0, 1, 1, i, i == W-1, 1, tag);
  endtask

  // scoreboard monitor: R4 R5 R7
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk(d_mux == d_cat && d_mux == d_ofs && v_mux == v_cat && v_mux == v_ofs,
          "R7 forms disagree", {d_cat, d_ofs}, {d_mux, d_mux});
      if (q.size() > 0 && q[0].due == cyc) begin
        chk(v_mux == 1'b1, {"R4 valid ", q[0].tag}, v_mux, 1);
        chk(int'(d_mux) == q[0].data, {"R4 data ", q[0].tag}, d_mux, q[0].data);
        last = q[0].data;
        void'(q.pop_front());
      end else begin
        chk(v_mux == 1'b0, "R5 valid idle", v_mux, 0);
        chk(int'(d_mux) == last, "R5 hold", d_mux, last);
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < P*W; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    chk(v_mux == 0 && v_cat == 0 && v_ofs == 0, "R9 reset valid", v_mux, 0);
    chk(d_mux == 0 && d_cat == 0 && d_ofs == 0, "R9 reset data", d_mux, 0);
    @(posedge clk); #1 rst = 0; mon_on = 1;
    // R8 back to back, R1 wrap after page 2
    fill(8'h10, "R8");
    fill(8'h20, "R8");
    fill(8'h30, "R1");
    // write page 0 again while reading page 1: R3 R10
    for (int i = 0; i < W; i++) step(1, i, 8'h40 + i, i == W-1, 1, 1, i, i == W-1, 1, "R10");
    drain("R2");
    drain("R2 wrap");
    idle(3);
    // R6: both sides disabled with every strobe high
    step(1, 3, 8'hEE, 1, 0, 1, 0, 1, 0, "R6");
    step(1, 4, 8'hDD, 1, 0, 1, 1, 1, 0, "R6");
    idle(2);
    drain("R6 read page");
    drain("R3");
    drain("R6 data");
    step(1, 3, 8'h77, 0, 1, 0, 0, 0, 1, "R6");
    step(0, 0, 0, 0, 1, 1, 3, 0, 1, "R6 write page held");
    idle(2);
    // R9 mid-run reset: pointers restart, storage kept
    @(posedge clk); #1 rst = 1; last = 0; wen = 0; ren = 0; wadv = 0; radv = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0; wp = 0; rp = 1;
    @(negedge clk);
    chk(v_mux == 0 && d_mux == 0, "R9 after reset", d_mux, 0);
    step(1, 2, 8'hA5, 0, 1, 1, 0, 1, 1, "R9 storage kept");
    step(0, 0, 0, 0, 1, 1, 5, 1, 1, "R1 restart");
    step(0, 0, 0, 0, 1, 1, 2, 0, 1, "R1 start page");
    idle(4);
    chk(q.size() == 0, "R4 pending reads", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule